// File: doc/BRIEF.md
# Privilege Stack Pointer Fetch Unit

When a control transfer through a gate moves execution to a more privileged level, the stack must change as well, because the stack segment has to run at the same privilege as the new code segment. This unit looks up the replacement stack. A request gives it the target privilege level, the current privilege level and the task-state base address held in the task register. The unit then reads the stack pointer word and the stack selector word for that level from the task-state area, and returns them as a pair with a one-cycle done strobe.

The task-state area holds 32-bit words. Only levels 0, 1 and 2 have stored pairs. For level n, the pointer word sits at byte offset 4+8n and the selector word at 8+8n. These entries are static, so the unit only reads them. It never writes them. Memory is reached through a simple word port: a one-cycle read request with an address, and later a response strobe with data. The new code segment, gate decoding, descriptor fetch and the pushing of the old stack all belong to other logic.

Top module: `psf_fetch_unit`

## Requirements
- R1: After reset, mem_req_o, done_o and err_o are 0, and sp_o and ss_sel_o are 0.
- R2: For an accepted valid request, the first memory read is a one-cycle mem_req_o pulse in the cycle after acceptance, with mem_addr_o = base + 4 + 8*target.
- R3: The second read is a one-cycle pulse in the cycle after the first response arrives, with mem_addr_o = base + 8 + 8*target.
- R4: done_o is high for exactly one cycle, in the cycle after the second response. In that same cycle sp_o holds the full 32-bit first response word. sp_o and ss_sel_o change only in a successful done cycle.
- R5: ss_sel_o equals bits 15:0 of the second response word; bits 31:16 of that word have no effect.
- R6: A request with target level 3 raises done_o and err_o together in the next cycle, makes no memory read, and leaves sp_o and ss_sel_o unchanged.
- R7: A request whose target level is numerically greater than or equal to the current level is handled the same way as in R6: error done, no read, outputs unchanged.
- R8: A request is accepted only while the unit is idle. A request raised during an operation, including the done cycle, is ignored.
- R9: The base address and target level are captured at acceptance. Changes on those inputs during an operation do not affect the read addresses.
- R10: A response strobe that arrives while no read is outstanding is ignored and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a stack lookup |
| tgt_pl_i | input | 2 | Target privilege level |
| cur_pl_i | input | 2 | Current privilege level |
| tss_base_i | input | 32 | Task-state base address from the task register |
| mem_req_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Memory response strobe |
| mem_rdata_i | input | 32 | Memory response word |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Request refused; valid with done_o |
| sp_o | output | 32 | New stack pointer |
| ss_sel_o | output | 16 | New stack segment selector |

## Verification
The collision of interest is a new request arriving in the same cycle that done_o is pulsed. The same applies to requests arriving during the read waits. The bench holds req_i high for the whole operation, with a different level and base applied every cycle. It expects the done pulse to finish the original operation unchanged, and the unit to return to idle without starting a second lookup. The bench's behavioural model tracks the phase of the operation and compares the read addresses, strobes and returned pair on every cycle.

// File: rtl/psf_pkg.sv
package psf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_SP,
    ST_WAIT_SP,
    ST_REQ_SS,
    ST_WAIT_SS,
    ST_FIN
  } psf_state_e;
endpackage

// File: rtl/psf_addr_gen.sv
module psf_addr_gen #(
  parameter int AW         = 32,
  parameter int PLW        = 2,
  parameter int WORD_BYTES = 4
) (
  input  logic [AW-1:0]  base_i,
  input  logic [PLW-1:0] pl_i,
  input  logic           is_ss_i,
  output logic [AW-1:0]  addr_o
);
  localparam int PairBytes = 2 * WORD_BYTES;

  logic [AW-1:0] pl_ext;
  logic [AW-1:0] off;

  assign pl_ext = {{(AW-PLW){1'b0}}, pl_i};
  // pair n starts one word past the link word; selector follows pointer
  assign off    = pl_ext * AW'(PairBytes) + (is_ss_i ? AW'(PairBytes) : AW'(WORD_BYTES));
  assign addr_o = base_i + off;
endmodule

// File: rtl/psf_ctrl.sv
module psf_ctrl
  import psf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ok_i,
  input  logic rvalid_i,
  output logic accept_o,
  output logic mem_req_o,
  output logic is_ss_o,
  output logic ld_sp_o,
  output logic ld_ss_o,
  output logic done_o
);
  psf_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = ok_i ? ST_REQ_SP : ST_FIN;
      ST_REQ_SP:  state_d = ST_WAIT_SP;
      ST_WAIT_SP: if (rvalid_i) state_d = ST_REQ_SS;
      ST_REQ_SS:  state_d = ST_WAIT_SS;
      ST_WAIT_SS: if (rvalid_i) state_d = ST_FIN;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign mem_req_o = (state_q == ST_REQ_SP) || (state_q == ST_REQ_SS);
  assign is_ss_o   = (state_q == ST_REQ_SS);
  assign ld_sp_o   = (state_q == ST_WAIT_SP) && rvalid_i;
  assign ld_ss_o   = (state_q == ST_WAIT_SS) && rvalid_i;
  assign done_o    = (state_q == ST_FIN);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !accept_o) |=> !$past(done_o) || !mem_req_o); // R8
endmodule

// File: rtl/psf_result.sv
module psf_result #(
  parameter int DW   = 32,
  parameter int SELW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            ok_i,
  input  logic            ld_sp_i,
  input  logic            ld_ss_i,
  input  logic [DW-1:0]   rdata_i,
  output logic            err_q_o,
  output logic [DW-1:0]   sp_o,
  output logic [SELW-1:0] sel_o
);
  logic [DW-1:0] sp_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_hold_q <= '0;
      sp_o      <= '0;
      sel_o     <= '0;
      err_q_o   <= 1'b0;
    end else begin
      if (accept_i) err_q_o   <= !ok_i;
      if (ld_sp_i)  sp_hold_q <= rdata_i;
      // publish the pair together so it appears with done
      if (ld_ss_i) begin
        sp_o  <= sp_hold_q;
        sel_o <= rdata_i[SELW-1:0];
      end
    end
  end
endmodule

// File: rtl/psf_fetch_unit.sv
module psf_fetch_unit #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int SELW        = 16,
  parameter int PLW         = 2,
  parameter int NUM_STK_LVL = 3,
  parameter int WORD_BYTES  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [PLW-1:0]  tgt_pl_i,
  input  logic [PLW-1:0]  cur_pl_i,
  input  logic [AW-1:0]   tss_base_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            done_o,
  output logic            err_o,
  output logic [DW-1:0]   sp_o,
  output logic [SELW-1:0] ss_sel_o
);
  localparam logic [PLW-1:0] LvlLimit = PLW'(NUM_STK_LVL);

  logic           ok, accept, is_ss, ld_sp, ld_ss, err_q;
  logic [AW-1:0]  base_q;
  logic [PLW-1:0] pl_q;

  // only stored levels, and only a move to a more privileged level
  assign ok = (tgt_pl_i < LvlLimit) && (tgt_pl_i < cur_pl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      pl_q   <= '0;
    end else if (accept) begin
      base_q <= tss_base_i;
      pl_q   <= tgt_pl_i;
    end
  end

  psf_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ok_i      (ok),
    .rvalid_i  (mem_rvalid_i),
    .accept_o  (accept),
    .mem_req_o (mem_req_o),
    .is_ss_o   (is_ss),
    .ld_sp_o   (ld_sp),
    .ld_ss_o   (ld_ss),
    .done_o    (done_o)
  );

  psf_addr_gen #(.AW(AW), .PLW(PLW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .base_i  (base_q),
    .pl_i    (pl_q),
    .is_ss_i (is_ss),
    .addr_o  (mem_addr_o)
  );

  psf_result #(.DW(DW), .SELW(SELW)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .ok_i     (ok),
    .ld_sp_i  (ld_sp),
    .ld_ss_i  (ld_ss),
    .rdata_i  (mem_rdata_i),
    .err_q_o  (err_q),
    .sp_o     (sp_o),
    .sel_o    (ss_sel_o)
  );

  assign err_o = done_o && err_q;

  AST_ERR_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(mem_req_o)); // R6
  AST_BAD_REQ_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !ok) |=> (done_o && err_o && !mem_req_o)); // R7
  AST_SS_FOLLOWS_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && is_ss) |-> mem_addr_o == base_q + AW'(2*WORD_BYTES) + AW'(2*WORD_BYTES) * AW'(pl_q)); // R3
  AST_PAIR_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sp_o) || !$stable(ss_sel_o)) |-> (done_o && !err_o)); // R4
  AST_BASE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !is_ss) |=> $stable(base_q)); // R9
endmodule

// File: tb/psf_fetch_unit_test.sv
module psf_fetch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  tgt = '0, cur = '0;
  logic [31:0] base = '0;
  logic        rvalid = 1'b0;
  logic [31:0] rdata = '0;
  logic        mem_req_o, done_o, err_o;
  logic [31:0] mem_addr_o, sp_o;
  logic [15:0] ss_sel_o;

  always #5 clk = ~clk;

  psf_fetch_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .tgt_pl_i(tgt), .cur_pl_i(cur),
    .tss_base_i(base), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata), .done_o(done_o), .err_o(err_o),
    .sp_o(sp_o), .ss_sel_o(ss_sel_o)
  );

  int n_cmp = 0, n_bad = 0;
  // stimulus knobs
  logic        s_req = 0, s_spur = 0;
  logic [1:0]  s_tgt = 0, s_cur = 0;
  logic [31:0] s_base = 0;
  int          mem_lat = 1;
  // memory model
  int          pend = 0;
  logic [31:0] paddr = 0;
  // reference model
  int          m_ph = 0;
  logic [1:0]  m_pl = 0;
  logic [31:0] m_base = 0, m_sp_hold = 0, m_sp = 0;
  logic [15:0] m_sel = 0;
  logic        m_err = 0;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {~a[15:0] | 16'h8001, a[15:0] ^ 16'h5A3C};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic exp_req;
    @(negedge clk);
    // compare DUT against model state
    exp_req = (m_ph == 1) || (m_ph == 3);
    chk(m_ph == 3 ? "R3" : (m_ph == 0 || m_ph == 5) ? "R6_R7" : "R2", "mem_req", 32'(mem_req_o), 32'(exp_req));
    if (exp_req)
      chk(m_ph == 1 ? "R2" : "R3", "mem_addr", mem_addr_o,
          m_base + 32'(m_ph == 1 ? 4 : 8) + 32'(8) * 32'(m_pl));
    chk("R4", "done", 32'(done_o), 32'(m_ph == 5));
    chk("R6_R7", "err", 32'(err_o), 32'(m_ph == 5 && m_err));
    chk("R4", "sp", sp_o, m_sp);
    chk("R5", "sel", 32'(ss_sel_o), 32'(m_sel));
    // memory response
    rvalid = 1'b0;
    rdata  = 32'hDEAD_BEEF;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin rvalid = 1'b1; rdata = mem_word(paddr); end
    end
    if (mem_req_o) begin pend = mem_lat; paddr = mem_addr_o; end
    if (s_spur) begin rvalid = 1'b1; rdata = 32'hC0DE_7777; end
    // drive request inputs
    req = s_req; tgt = s_tgt; cur = s_cur; base = s_base;
    // advance model
    case (m_ph)
      0: if (req) begin
           if (tgt == 2'd3 || tgt >= cur) begin m_err = 1; m_ph = 5; end
           else begin m_err = 0; m_pl = tgt; m_base = base; m_ph = 1; end
         end
      1: m_ph = 2;
      2: if (rvalid) begin m_sp_hold = rdata; m_ph = 3; end
      3: m_ph = 4;
      4: if (rvalid) begin m_sp = m_sp_hold; m_sel = rdata[15:0]; m_ph = 5; end
      default: m_ph = 0;
    endcase
  endtask

  task automatic finish_op();
    for (int i = 0; i < 60 && m_ph != 0; i++) tick();
    tick();
  endtask

  task automatic run(logic [1:0] t, logic [1:0] c, logic [31:0] b, int lat);
    mem_lat = lat;
    s_req = 1; s_tgt = t; s_cur = c; s_base = b;
    tick();
    s_req = 0;
    finish_op();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    tick(); tick();
    // R2 R3 R4 R5: valid lookups for each stored level, various latencies
    run(2'd0, 2'd3, 32'h0041_E000, 1);
    run(2'd1, 2'd3, 32'h0000_1000, 3);
    run(2'd2, 2'd3, 32'hFFFF_FFA0, 5);
    run(2'd1, 2'd2, 32'h1234_5678, 2);
    run(2'd0, 2'd1, 32'h8000_0004, 4);
    // R6: level 3 target, R7: not more privileged
    run(2'd3, 2'd3, 32'h0000_2000, 1);
    run(2'd3, 2'd0, 32'h0000_2000, 1);
    run(2'd1, 2'd1, 32'h0000_3000, 1);
    run(2'd2, 2'd1, 32'h0000_3000, 1);
    run(2'd0, 2'd0, 32'h0000_3000, 1);
    // R8 R9: req held through the operation incl. the done cycle, inputs changing
    mem_lat = 2;
    s_req = 1; s_tgt = 2'd2; s_cur = 2'd3; s_base = 32'h0050_0000;
    tick();
    for (int i = 0; i < 40 && m_ph != 0; i++) begin
      s_req  = (m_ph != 0);
      s_tgt  = 2'(i);
      s_cur  = 2'd3;
      s_base = 32'h0900_0000 + 32'(i * 16);
      tick();
    end
    s_req = 0;
    tick(); tick();
    // R8: error done cycle colliding with a held request
    s_req = 1; s_tgt = 2'd3; s_cur = 2'd3;
    tick();
    s_req = (m_ph != 0);
    tick();
    s_req = 0;
    finish_op();
    // R10: stray responses while idle
    s_spur = 1;
    repeat (4) tick();
    s_spur = 0;
    tick();
    run(2'd2, 2'd3, 32'h0000_0000, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule